// File: doc/BRIEF.md
# Four-Channel Byte DMA Engine

This block moves bytes from one place to another on a simple memory request bus, working for peripherals or for software. It has four channels. Each channel holds its own read and write start addresses, an address mode for each side, a block length, a repeat count, a burst length and a trigger choice. One bus engine serves all channels. It copies every byte as a read followed by a write, and it gives the bus to one channel at a time, for one burst at a time.

Software arms a channel with a start pulse. Once armed, the channel asks for a burst each time its trigger allows. When the last byte of its transaction is written, the channel raises a one-cycle completion flag. It can then return its addresses to their starting values, and it can hand off to its partner channel. The partner pairs are (0,1) and (2,3). The block is the only master on its bus.

Top module: `dma_ctrl`

## Requirements
- R1: A `ch_start` pulse on an enabled, idle channel sets only that channel's `ch_busy` bit on the next clock edge. The other channels' configuration has no effect on it.
- R2: A block-length field value v gives v+1 bytes per block. A repeat field value n of 1 or more gives exactly n blocks, so one transaction writes (v+1)*n bytes and then ends.
- R3: A repeat field value of 0 re-runs the block with no end. The channel stays busy and never signals completion until its enable is removed.
- R4: Each side has its own 2-bit address mode: 0 keeps the address fixed, 1 adds one after every byte, 2 subtracts one after every byte, 3 acts as fixed. Addresses carry on across block boundaries.
- R5: Each byte is a read at the read address whose returned data is then written at the write address. A request holds `mem_valid`, `mem_addr` and `mem_we` unchanged until `mem_ready` is seen.
- R6: The 2-bit burst code c gives 2^c bytes per trigger (1, 2, 4 or 8). A burst ends early only at the end of the transaction. No other channel's byte comes between the bytes of a burst.
- R7: A trigger field of 0 lets bursts run one after another with no wait. A value k from 1 to the number of request lines makes each burst wait for `hw_req[k-1]` to be high.
- R8: `ch_done[c]` is high for exactly one cycle when the last byte of a transaction is written. `ch_busy[c]` is already low in that cycle. After reset, busy, done and `mem_valid` are all low.
- R9: If the reload bit is set, the addresses go back to their configured values when a transaction ends. If it is clear, the next transaction carries on from where the last one stopped.
- R10: If `ch_link[c]` is set, the completion of channel c starts its partner (c XOR 1). The partner's busy bit rises in the cycle after c's done pulse.
- R11: With `prio_rr` at 0, the lowest-numbered requesting channel wins. With `prio_rr` at 1, the search begins at the channel after the last one granted. Arbitration happens only between bursts.
- R12: When a channel's enable is low and it does not own the bus, it is idle, it ignores start pulses, and its addresses follow the configured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NCH | Per-channel enable |
| ch_start | input | NCH | Per-channel start pulse |
| ch_reload | input | NCH | Restore addresses at transaction end |
| ch_link | input | NCH | Start the partner channel on completion |
| ch_src | input | NCH*AW | Read start addresses |
| ch_dst | input | NCH*AW | Write start addresses |
| ch_src_mode | input | NCH*2 | Read address mode |
| ch_dst_mode | input | NCH*2 | Write address mode |
| ch_burst | input | NCH*2 | Burst code |
| ch_blk | input | NCH*BLKW | Block length minus one |
| ch_rpt | input | NCH*RPTW | Repeat count, 0 = endless |
| ch_trig | input | NCH*TSW | Trigger select |
| hw_req | input | NREQ | Hardware request lines |
| prio_rr | input | 1 | 0 fixed priority, 1 round-robin |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_valid | output | 1 | Bus request |
| mem_ready | input | 1 | Bus accepts request |
| mem_rdata | input | 8 | Bus read data |
| ch_busy | output | NCH | Transaction in progress |
| ch_done | output | NCH | One-cycle completion flag |

## Verification
The hardest case to reach from the ports is two channels armed in the same cycle. That is the only way the burst boundaries and the arbitration order can be seen in the sequence of read addresses. The bench starts two channels with one shared start pulse, gives them separate read regions, and checks the region of each read in fixed and in round-robin order. The memory model adds random wait cycles, so the handshake hold rule and the grouping of bursts are tested under stalls. Seeded random single-channel transfers are compared byte for byte with a model copy.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_HOLD  = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        EN_IDLE  = 2'd0,
        EN_READ  = 2'd1,
        EN_WRITE = 2'd2
    } eng_state_e;

    typedef struct packed {
        eng_state_e st;
        logic [2:0] left;
        logic [7:0] data;
    } eng_t;

    function automatic logic [31:0] next_addr(input logic [31:0] a, input amode_e m);
        case (m)
            AM_INC:  return a + 32'd1;
            AM_DEC:  return a - 32'd1;
            default: return a;
        endcase
    endfunction

    function automatic logic [2:0] burst_left(input logic [1:0] code);
        logic [3:0] n;
        n = 4'd1 << code;
        return 3'(n - 4'd1);
    endfunction

endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
    parameter int NCH = 4,
    parameter int IW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic           prio_rr,
    input  logic           take,
    output logic [NCH-1:0] gnt,
    output logic [IW-1:0]  gidx,
    output logic           any
);
    logic [IW-1:0] ptr;

    always_comb begin
        int k;
        gnt  = '0;
        gidx = '0;
        any  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            k = prio_rr ? ((int'(ptr) + 1 + i) % NCH) : i;
            if (!any && req[k]) begin
                any    = 1'b1;
                gnt[k] = 1'b1;
                gidx   = IW'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       ptr <= IW'(NCH - 1);
        else if (take) ptr <= gidx;
    end

    assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    assert_grant_requested_R11: assert property (@(posedge clk) disable iff (rst)
        any |-> ((gnt & req) != '0));

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW   = 16,
    parameter int BLKW = 16,
    parameter int RPTW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            start,
    input  logic            owned,
    input  logic            step,
    input  logic            reload,
    input  logic [AW-1:0]   cfg_src,
    input  logic [AW-1:0]   cfg_dst,
    input  logic [1:0]      src_mode,
    input  logic [1:0]      dst_mode,
    input  logic [BLKW-1:0] cfg_blk,
    input  logic [RPTW-1:0] cfg_rpt,
    output logic [AW-1:0]   src_addr,
    output logic [AW-1:0]   dst_addr,
    output logic            last,
    output logic            active,
    output logic            done
);
    logic [BLKW-1:0] blk_left;
    logic [RPTW-1:0] rpt_left;

    assign last = (blk_left == '0) && (cfg_rpt != '0) && (rpt_left == RPTW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            done     <= 1'b0;
            blk_left <= '0;
            rpt_left <= '0;
            src_addr <= '0;
            dst_addr <= '0;
        end else begin
            done <= 1'b0;
            if (!en && !owned) begin
                active   <= 1'b0;
                src_addr <= cfg_src;
                dst_addr <= cfg_dst;
            end else if (!active) begin
                if (start && en) begin
                    active   <= 1'b1;
                    blk_left <= cfg_blk;
                    rpt_left <= cfg_rpt;
                end
            end else if (step) begin
                src_addr <= AW'(next_addr(32'(src_addr), amode_e'(src_mode)));
                dst_addr <= AW'(next_addr(32'(dst_addr), amode_e'(dst_mode)));
                if (blk_left == '0) begin
                    if (last) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        if (reload) begin
                            src_addr <= cfg_src;
                            dst_addr <= cfg_dst;
                        end
                    end else begin
                        blk_left <= cfg_blk;
                        if (cfg_rpt != '0) rpt_left <= rpt_left - RPTW'(1);
                    end
                end else begin
                    blk_left <= blk_left - BLKW'(1);
                end
            end
        end
    end

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !active);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int AW   = 16,
    parameter int BLKW = 16,
    parameter int RPTW = 8,
    parameter int NREQ = 4,
    parameter int TSW  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH-1:0]      ch_en,
    input  logic [NCH-1:0]      ch_start,
    input  logic [NCH-1:0]      ch_reload,
    input  logic [NCH-1:0]      ch_link,
    input  logic [NCH*AW-1:0]   ch_src,
    input  logic [NCH*AW-1:0]   ch_dst,
    input  logic [NCH*2-1:0]    ch_src_mode,
    input  logic [NCH*2-1:0]    ch_dst_mode,
    input  logic [NCH*2-1:0]    ch_burst,
    input  logic [NCH*BLKW-1:0] ch_blk,
    input  logic [NCH*RPTW-1:0] ch_rpt,
    input  logic [NCH*TSW-1:0]  ch_trig,
    input  logic [NREQ-1:0]     hw_req,
    input  logic                prio_rr,
    output logic [AW-1:0]       mem_addr,
    output logic [7:0]          mem_wdata,
    output logic                mem_we,
    output logic                mem_valid,
    input  logic                mem_ready,
    input  logic [7:0]          mem_rdata,
    output logic [NCH-1:0]      ch_busy,
    output logic [NCH-1:0]      ch_done
);
    localparam int IW = $clog2(NCH);

    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [NCH-1:0] last_v, act_v, done_v, step_v, owned_v, start_v, trig_ok, req_v, gnt_v;
    logic [IW-1:0]  gidx, owner;
    logic           any, take;
    eng_t           eng;

    always_comb begin
        logic [TSW-1:0] sel;
        for (int c = 0; c < NCH; c++) begin
            sel        = ch_trig[c*TSW +: TSW];
            trig_ok[c] = (sel == '0);
            for (int r = 0; r < NREQ; r++)
                if (sel == TSW'(r + 1)) trig_ok[c] = trig_ok[c] | hw_req[r];
        end
    end

    assign req_v = act_v & ch_en & trig_ok;
    assign take  = (eng.st == EN_IDLE) && any;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int P = ((c ^ 1) < NCH) ? (c ^ 1) : c;
        if (P != c) begin : g_pair
            assign start_v[c] = ch_start[c] | (ch_link[P] & done_v[P]);
        end else begin : g_solo
            assign start_v[c] = ch_start[c];
        end
        assign step_v[c]  = (eng.st == EN_WRITE) && mem_ready && (owner == IW'(c));
        assign owned_v[c] = (eng.st != EN_IDLE) && (owner == IW'(c));

        dma_chan #(.AW(AW), .BLKW(BLKW), .RPTW(RPTW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .en       (ch_en[c]),
            .start    (start_v[c]),
            .owned    (owned_v[c]),
            .step     (step_v[c]),
            .reload   (ch_reload[c]),
            .cfg_src  (ch_src[c*AW +: AW]),
            .cfg_dst  (ch_dst[c*AW +: AW]),
            .src_mode (ch_src_mode[c*2 +: 2]),
            .dst_mode (ch_dst_mode[c*2 +: 2]),
            .cfg_blk  (ch_blk[c*BLKW +: BLKW]),
            .cfg_rpt  (ch_rpt[c*RPTW +: RPTW]),
            .src_addr (src_a[c]),
            .dst_addr (dst_a[c]),
            .last     (last_v[c]),
            .active   (act_v[c]),
            .done     (done_v[c])
        );
    end

    dma_arb #(.NCH(NCH), .IW(IW)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req_v),
        .prio_rr (prio_rr),
        .take    (take),
        .gnt     (gnt_v),
        .gidx    (gidx),
        .any     (any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            eng   <= '{st: EN_IDLE, left: '0, data: '0};
            owner <= '0;
        end else begin
            case (eng.st)
                EN_IDLE: if (any) begin
                    owner    <= gidx;
                    eng.left <= burst_left(ch_burst[int'(gidx)*2 +: 2]);
                    eng.st   <= EN_READ;
                end
                EN_READ: if (mem_ready) begin
                    eng.data <= mem_rdata;
                    eng.st   <= EN_WRITE;
                end
                EN_WRITE: if (mem_ready) begin
                    if (last_v[owner] || eng.left == '0) begin
                        eng.st <= EN_IDLE;
                    end else begin
                        eng.left <= eng.left - 3'd1;
                        eng.st   <= EN_READ;
                    end
                end
                default: eng.st <= EN_IDLE;
            endcase
        end
    end

    assign mem_valid = (eng.st != EN_IDLE);
    assign mem_we    = (eng.st == EN_WRITE);
    assign mem_addr  = (eng.st == EN_WRITE) ? dst_a[owner] : src_a[owner];
    assign mem_wdata = eng.data;
    assign ch_busy   = act_v;
    assign ch_done   = done_v;

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));
    assert_owner_busy_R6: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ch_busy[owner]);

endmodule

// File: tb/tb_dma_ctrl.sv
module tb_dma_ctrl;
    localparam int NCH = 4, AW = 16, BLKW = 16, RPTW = 8, NREQ = 4, TSW = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic [NCH-1:0]      ch_en = '0, ch_start = '0, ch_reload = '0, ch_link = '0;
    logic [NCH*AW-1:0]   ch_src = '0, ch_dst = '0;
    logic [NCH*2-1:0]    ch_src_mode = '0, ch_dst_mode = '0, ch_burst = '0;
    logic [NCH*BLKW-1:0] ch_blk = '0;
    logic [NCH*RPTW-1:0] ch_rpt = '0;
    logic [NCH*TSW-1:0]  ch_trig = '0;
    logic [NREQ-1:0]     hw_req = '0;
    logic                prio_rr = 1'b0;
    logic [AW-1:0]       mem_addr;
    logic [7:0]          mem_wdata, mem_rdata = '0;
    logic                mem_we, mem_valid, mem_ready = 1'b0;
    logic [NCH-1:0]      ch_busy, ch_done;

    dma_ctrl #(.NCH(NCH), .AW(AW), .BLKW(BLKW), .RPTW(RPTW), .NREQ(NREQ), .TSW(TSW)) dut (.*);

    always #4 clk = ~clk;

    logic [7:0] mem [256];
    logic [7:0] ref_m [256];
    logic [7:0] rd_log [64];
    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, rd_cnt = 0, hold_err = 0, done_busy_err = 0;
    int done_cnt [NCH];
    logic [7:0] last_wa = '0;
    logic hold_chk = 1'b0, p_we = 1'b0, finished = 1'b0;
    logic [AW-1:0] p_addr = '0;
    int seed_v;

    always @(negedge clk) begin
        logic rdy;
        if (!rst) begin
            rdy = ($urandom % 4) != 0;
            mem_ready = rdy;
            mem_rdata = mem[mem_addr[7:0]];
            if (hold_chk && (!mem_valid || mem_addr != p_addr || mem_we != p_we)) hold_err++;
            hold_chk = mem_valid && !rdy;
            p_addr = mem_addr;
            p_we = mem_we;
            if (mem_valid && rdy) begin
                if (mem_we) begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    last_wa = mem_addr[7:0];
                    wr_cnt++;
                end else begin
                    rd_log[rd_cnt % 64] = mem_addr[7:0];
                    rd_cnt++;
                end
            end
            for (int c = 0; c < NCH; c++)
                if (ch_done[c]) begin
                    done_cnt[c]++;
                    if (ch_busy[c]) done_busy_err++;
                end
        end
    end

    task automatic check(input logic ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] nx(input logic [7:0] a, input int m);
        if (m == 1) return a + 8'd1;
        if (m == 2) return a - 8'd1;
        return a;
    endfunction

    task automatic set_ch(input int c, input int src, input int dst, input int sm, input int dm,
                          input int blk, input int rpt, input int bu, input int tr, input bit rl, input bit lk);
        ch_src[c*AW +: AW]      = AW'(src);
        ch_dst[c*AW +: AW]      = AW'(dst);
        ch_src_mode[c*2 +: 2]   = 2'(sm);
        ch_dst_mode[c*2 +: 2]   = 2'(dm);
        ch_blk[c*BLKW +: BLKW]  = BLKW'(blk);
        ch_rpt[c*RPTW +: RPTW]  = RPTW'(rpt);
        ch_burst[c*2 +: 2]      = 2'(bu);
        ch_trig[c*TSW +: TSW]   = TSW'(tr);
        ch_reload[c]            = rl;
        ch_link[c]              = lk;
    endtask

    task automatic pulse_start(input logic [NCH-1:0] m);
        @(negedge clk) ch_start = m;
        @(negedge clk) ch_start = '0;
    endtask

    task automatic wait_done(input int c, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (ch_done[c]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (ch_busy == '0 && !mem_valid) begin ok = 1'b1; break; end
        end
    endtask

    initial begin
        bit ok;
        int w0, d0, mism;
        seed_v = $urandom(32'd4242);
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_m[i] = mem[i];
        end
        for (int c = 0; c < NCH; c++) done_cnt[c] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ch_busy == '0 && ch_done == '0 && !mem_valid, "R8 reset state", int'(ch_busy), 0);

        // seeded random single-channel transfers: R1 R2 R4 R5
        for (int t = 0; t < 10; t++) begin
            int c, sm, dm, blk, rpt, bu, total;
            logic [7:0] s, d;
            c = $urandom % 4; sm = $urandom % 4; dm = $urandom % 3;
            blk = $urandom % 6; rpt = 1 + $urandom % 3; bu = $urandom % 4;
            s = 8'($urandom); d = 8'($urandom);
            set_ch(c, s, d, sm, dm, blk, rpt, bu, 0, 1'b0, 1'b0);
            total = (blk + 1) * rpt;
            for (int i = 0; i < total; i++) begin
                ref_m[d] = ref_m[s];
                s = nx(s, sm);
                d = nx(d, dm);
            end
            @(negedge clk) ch_en = NCH'(1) << c;
            @(negedge clk);
            w0 = wr_cnt; d0 = done_cnt[c];
            pulse_start(NCH'(1) << c);
            check(ch_busy == (NCH'(1) << c), "R1 only started channel busy", int'(ch_busy), 1 << c);
            wait_done(c, ok);
            check(ok, "R8 done seen", int'(ok), 1);
            @(negedge clk);
            check(wr_cnt - w0 == total, "R2 byte count", wr_cnt - w0, total);
            check(done_cnt[c] - d0 == 1, "R8 single done", done_cnt[c] - d0, 1);
            mism = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== ref_m[i]) mism++;
            check(mism == 0, "R4 memory matches model copy", mism, 0);
            ch_en = '0;
        end

        // fixed priority with bursts of 4: R11 R6
        set_ch(0, 8'h00, 8'hA0, 1, 1, 7, 1, 2, 0, 1'b0, 1'b0);
        set_ch(1, 8'h40, 8'hC0, 1, 1, 7, 1, 2, 0, 1'b0, 1'b0);
        prio_rr = 1'b0;
        @(negedge clk) ch_en = 4'b0011;
        @(negedge clk) rd_cnt = 0;
        pulse_start(4'b0011);
        wait_idle(ok);
        mism = 0;
        for (int i = 0; i < 8; i++) if (rd_log[i] >= 8'h40) mism++;
        check(ok && rd_cnt == 16 && mism == 0, "R11 fixed priority channel 0 first", mism, 0);

        // round-robin: R11 R6
        ch_en = '0;
        @(negedge clk) prio_rr = 1'b1;
        @(negedge clk) ch_en = 4'b0011;
        @(negedge clk) rd_cnt = 0;
        pulse_start(4'b0011);
        wait_idle(ok);
        mism = 0;
        for (int g = 0; g < 4; g++)
            for (int i = 1; i < 4; i++)
                if ((rd_log[g*4+i] >= 8'h40) != (rd_log[g*4] >= 8'h40)) mism++;
        check(ok && mism == 0, "R6 burst not split", mism, 0);
        mism = 0;
        for (int g = 1; g < 4; g++)
            if ((rd_log[g*4] >= 8'h40) == (rd_log[g*4-4] >= 8'h40)) mism++;
        check(mism == 0, "R11 round-robin alternates bursts", mism, 0);
        ch_en = '0;
        prio_rr = 1'b0;

        // hardware trigger: R7
        set_ch(2, 8'h10, 8'h90, 1, 1, 3, 1, 1, 2, 1'b0, 1'b0);
        @(negedge clk) ch_en = 4'b0100;
        @(negedge clk) w0 = wr_cnt;
        pulse_start(4'b0100);
        repeat (40) @(negedge clk);
        check(wr_cnt == w0 && ch_busy[2], "R7 waits for request line", wr_cnt - w0, 0);
        hw_req[1] = 1'b1;
        wait_done(2, ok);
        @(negedge clk);
        check(ok && wr_cnt - w0 == 4, "R7 runs when request high", wr_cnt - w0, 4);
        hw_req = '0;
        ch_en = '0;

        // endless repeat: R3 R12
        set_ch(1, 8'h05, 8'hF5, 0, 0, 1, 0, 0, 0, 1'b0, 1'b0);
        @(negedge clk) ch_en = 4'b0010;
        @(negedge clk) begin w0 = wr_cnt; d0 = done_cnt[1]; end
        pulse_start(4'b0010);
        repeat (120) @(negedge clk);
        check(ch_busy[1] && done_cnt[1] == d0 && wr_cnt - w0 > 4, "R3 keeps repeating", wr_cnt - w0, 5);
        ch_en = '0;
        repeat (20) @(negedge clk);
        check(!ch_busy[1] && done_cnt[1] == d0, "R3 stops on disable", int'(ch_busy[1]), 0);

        // reload: R9
        set_ch(3, 8'h20, 8'hE0, 1, 1, 1, 1, 0, 0, 1'b0, 1'b0);
        @(negedge clk) ch_en = 4'b1000;
        for (int k = 0; k < 2; k++) begin pulse_start(4'b1000); wait_done(3, ok); end
        check(last_wa == 8'hE3, "R9 no reload continues", int'(last_wa), 'hE3);
        ch_en = '0;
        @(negedge clk) ch_reload[3] = 1'b1;
        @(negedge clk) ch_en = 4'b1000;
        for (int k = 0; k < 2; k++) begin pulse_start(4'b1000); wait_done(3, ok); end
        check(last_wa == 8'hE1, "R9 reload restores", int'(last_wa), 'hE1);
        ch_en = '0;

        // link 2 -> 3: R10 R8
        set_ch(2, 8'h30, 8'hB0, 1, 1, 1, 1, 0, 0, 1'b0, 1'b1);
        set_ch(3, 8'h34, 8'hB8, 1, 1, 1, 1, 0, 0, 1'b0, 1'b0);
        @(negedge clk) ch_en = 4'b1100;
        @(negedge clk) d0 = done_cnt[3];
        pulse_start(4'b0100);
        check(!ch_busy[3], "R10 partner idle before handoff", int'(ch_busy[3]), 0);
        wait_done(2, ok);
        check(ok && !ch_busy[2], "R8 busy low with done", int'(ch_busy[2]), 0);
        @(negedge clk);
        check(ch_busy[3], "R10 partner started", int'(ch_busy[3]), 1);
        wait_done(3, ok);
        check(ok, "R10 partner completes", int'(ok), 1);
        ch_en = '0;

        // disabled start ignored: R12
        set_ch(0, 8'h00, 8'h60, 1, 1, 1, 1, 0, 0, 1'b0, 1'b0);
        @(negedge clk) w0 = wr_cnt;
        pulse_start(4'b0001);
        repeat (10) @(negedge clk);
        check(!ch_busy[0] && wr_cnt == w0, "R12 start ignored while disabled", int'(ch_busy[0]), 0);

        check(hold_err == 0, "R5 request held until ready", hold_err, 0);
        check(done_busy_err == 0, "R8 done never with busy", done_busy_err, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule